// File: doc/BRIEF.md
# Maskable Interrupt Pin Controller

This block collects single-cycle event pulses from the rest of the chip into sticky status bits spread over a bank of status registers. Each status register has a companion mask register. A mask bit of 1 lets its event request service. The block drives one active-low, open-drain interrupt line toward the host. The line is modelled as a pull-low enable, `irq_pull_o`, which is either pulling the wire low or leaving it to an external pull-up. It never drives the line high.

The host handles an interrupt in three steps. It reads the status registers to learn which events fired and acts on them. It clears the status bits it has handled with write-one-to-clear. It then releases the line by writing a dedicated release bit in a control register. Releasing the line and clearing status are separate actions, so status can stay pending while the line is idle. After a release, the line is re-armed only by a fresh unmasked event pulse, never by leftover status.

The register port is a plain single-cycle access. A write is performed at the clock edge while `wr_en_i` is high. Read data is a combinational function of `addr_i` and the current register contents.

Top module: `irq_pin_ctrl_top`

## Requirements
- R1: After reset every status bit and every mask bit reads 0 and `irq_pull_o` is 0.
- R2: An event pulse on `evt_i[i*REG_W+j]` sets bit j of status register i, which is read at address i. The bit is visible after the next clock edge and stays set whatever the mask holds.
- R3: A write to status address i clears exactly those status bits written with 1. Bits written with 0 keep their value.
- R4: Mask register i is read and written at address MASK_BASE+i, which is 8+i by default. Only mask bits of 1 let the matching event assert the line.
- R5: An event pulse whose mask bit is 1 makes `irq_pull_o` 1 after the next clock edge. An event pulse whose mask bit is 0 leaves `irq_pull_o` unchanged.
- R6: Writing address 6 with bit 0 set makes `irq_pull_o` 0 after the clock edge. Address 6 always reads back 0.
- R7: If an unmasked event pulse arrives in the same cycle as the release write, `irq_pull_o` stays 1.
- R8: Once released, `irq_pull_o` stays 0 while status bits remain pending, until a new unmasked event pulse arrives. Clearing status bits does not release the line.
- R9: If a status bit is written with 1 in the same cycle as its own event pulse, the bit stays set.
- R10: Addresses 5 and 7, and addresses above MASK_BASE+NUM_REGS-1, read 0. Writes to them change no register.
- R11: Setting a mask bit for a status bit that is already pending does not assert `irq_pull_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_REGS*REG_W | Event pulses, one bit per status bit |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | REG_W | Write data |
| rdata_o | output | REG_W | Read data for `addr_i` |
| irq_pull_o | output | 1 | Pull-low enable for the open-drain interrupt line |

## Verification
The bench builds the block with its default parameters: five 8-bit status registers, masks starting at address 8, and a 4-bit address. With these values it can reach the highest event bit (39) and the last mask address (12). It can also reach both gap addresses around the control register and the unused top of the address space. The vector walk covers the orderings that matter: events that arrive while masked and are unmasked later, a release that coincides with an event, and status that is cleared while the line stays low. It then checks a reset in the middle of operation.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned CTRL_ADDR = 6;
  localparam int unsigned REL_BIT   = 0;
endpackage

// File: rtl/irq_reg_slice.sv
module irq_reg_slice #(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] evt_i,
  input  logic             stat_wr_i,
  input  logic             mask_wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] stat_o,
  output logic [REG_W-1:0] mask_o,
  output logic             hit_o
);
  logic [REG_W-1:0] stat_q, mask_q, clr_vec;

  assign clr_vec = stat_wr_i ? wdata_i : '0;

  // set wins over clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr_vec) | evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_wr_i) mask_q <= wdata_i;
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign hit_o  = |(evt_i & mask_q);

  // R2
  evt_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));
  // R3
  w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr_i && evt_i == '0) |=> ((stat_q & $past(wdata_i)) == '0));
  // R4
  mask_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_wr_i |=> (mask_q == $past(wdata_i)));
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv #(
  parameter int unsigned NUM_REGS = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_REGS-1:0] hit_i,
  input  logic                rel_i,
  output logic                pull_o
);
  logic pull_q, any_hit;

  assign any_hit = |hit_i;

  // new unmasked event beats a release in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pull_q <= 1'b0;
    else         pull_q <= any_hit | (pull_q & ~rel_i);
  end

  assign pull_o = pull_q;

  // R5
  hit_assert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_hit |=> pull_q);
  // R6
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_i && !any_hit) |=> !pull_q);
  // R8
  no_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pull_q && !any_hit) |=> !pull_q);
endmodule

// File: rtl/irq_pin_ctrl_top.sv
module irq_pin_ctrl_top #(
  parameter int unsigned NUM_REGS  = 5,
  parameter int unsigned REG_W     = 8,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned MASK_BASE = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_REGS*REG_W-1:0] evt_i,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [REG_W-1:0]          wdata_i,
  output logic [REG_W-1:0]          rdata_o,
  output logic                      irq_pull_o
);
  import irq_pkg::*;

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  logic [NUM_REGS-1:0][REG_W-1:0] stat, mask;
  logic [NUM_REGS-1:0]            hit;
  logic                           rel;

  assign rel = wr_en_i && addr_i == CTRL_A && wdata_i[REL_BIT];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slice
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(g);
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_BASE + g);
    irq_reg_slice #(.REG_W(REG_W)) i_slice (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .evt_i    (evt_i[g*REG_W +: REG_W]),
      .stat_wr_i(wr_en_i && addr_i == STAT_A),
      .mask_wr_i(wr_en_i && addr_i == MASK_A),
      .wdata_i  (wdata_i),
      .stat_o   (stat[g]),
      .mask_o   (mask[g]),
      .hit_o    (hit[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr_i == ADDR_W'(i))             rdata_o = stat[i];
      if (addr_i == ADDR_W'(MASK_BASE + i)) rdata_o = mask[i];
    end
  end

  irq_pin_drv #(.NUM_REGS(NUM_REGS)) i_pin (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hit_i (hit),
    .rel_i (rel),
    .pull_o(irq_pull_o)
  );

  // R6
  ctrl_rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == CTRL_A) |-> (rdata_o == '0));
  // R7
  rel_race_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel && |hit) |=> irq_pull_o);
endmodule

// File: tb/test_irq_pin_ctrl_top.sv
module test_irq_pin_ctrl_top;
  typedef struct packed {
    logic        we;
    logic [3:0]  addr;
    logic [7:0]  wdata;
    logic [39:0] evt;
    logic [3:0]  raddr;
    logic [7:0]  exp_rd;
    logic        exp_pull;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'd0,  8'h00, 40'h0,           4'd0,  8'h00, 1'b0}, // R1 idle
    '{1'b0, 4'd0,  8'h00, 40'h8,           4'd0,  8'h08, 1'b0}, // R2 R5 masked evt
    '{1'b1, 4'd8,  8'h08, 40'h0,           4'd8,  8'h08, 1'b0}, // R4 R11 unmask pending
    '{1'b0, 4'd0,  8'h00, 40'h8,           4'd0,  8'h08, 1'b1}, // R5 unmasked evt
    '{1'b1, 4'd0,  8'h00, 40'h0,           4'd0,  8'h08, 1'b1}, // R3 zero write keeps
    '{1'b1, 4'd0,  8'h08, 40'h0,           4'd0,  8'h00, 1'b1}, // R3 R8 w1c, pin stays
    '{1'b1, 4'd6,  8'h01, 40'h0,           4'd6,  8'h00, 1'b0}, // R6 release
    '{1'b0, 4'd0,  8'h00, 40'h10_0000,     4'd2,  8'h10, 1'b0}, // R2 masked reg2
    '{1'b1, 4'd10, 8'h10, 40'h0,           4'd10, 8'h10, 1'b0}, // R11 unmask pending
    '{1'b1, 4'd6,  8'h01, 40'h10_0000,     4'd2,  8'h10, 1'b1}, // R7 race
    '{1'b1, 4'd6,  8'h01, 40'h0,           4'd6,  8'h00, 1'b0}, // R6 release
    '{1'b0, 4'd0,  8'h00, 40'h0,           4'd2,  8'h10, 1'b0}, // R8 pending, no rearm
    '{1'b1, 4'd2,  8'h10, 40'h10_0000,     4'd2,  8'h10, 1'b1}, // R9 set beats clear
    '{1'b1, 4'd5,  8'hFF, 40'h0,           4'd5,  8'h00, 1'b1}, // R10 gap addr 5
    '{1'b1, 4'd7,  8'hFF, 40'h0,           4'd7,  8'h00, 1'b1}, // R10 gap addr 7
    '{1'b1, 4'd15, 8'hFF, 40'h80_0000_0000, 4'd4, 8'h80, 1'b1}, // R10 R2 top bit
    '{1'b1, 4'd12, 8'hFF, 40'h0,           4'd12, 8'hFF, 1'b1}, // R4 last mask
    '{1'b1, 4'd6,  8'h01, 40'h0,           4'd4,  8'h80, 1'b0}, // R6 R8
    '{1'b0, 4'd0,  8'h00, 40'h80_0000_0000, 4'd4, 8'h80, 1'b1}  // R5 top bit rearm
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [39:0] evt_i = '0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        irq_pull_o;
  int n_chk = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  irq_pin_ctrl_top i_irq_pin_ctrl_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_pull_o(irq_pull_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 pull", {7'd0, irq_pull_o}, 8'h00);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      wr_en_i = VEC[i].we; addr_i = VEC[i].addr;
      wdata_i = VEC[i].wdata; evt_i = VEC[i].evt;
      @(posedge clk_i);
      #1;
      wr_en_i = 1'b0; evt_i = '0; addr_i = VEC[i].raddr;
      #1;
      chk($sformatf("vec%0d rdata", i), rdata_o, VEC[i].exp_rd);
      chk($sformatf("vec%0d pull", i), {7'd0, irq_pull_o}, {7'd0, VEC[i].exp_pull});
    end
    // R1 reset mid-run clears status, mask and pin
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1 pull after reset", {7'd0, irq_pull_o}, 8'h00);
    addr_i = 4'd4; #1;
    chk("R1 status after reset", rdata_o, 8'h00);
    addr_i = 4'd12; #1;
    chk("R1 mask after reset", rdata_o, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R5 masked after reset: event leaves pin idle
    evt_i = 40'h80_0000_0000;
    @(posedge clk_i); #1; evt_i = '0; #1;
    chk("R5 masked after reset", {7'd0, irq_pull_o}, 8'h00);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule